// File: doc/BRIEF.md
# Fast Scratch Register File

This block is a sixteen-word, 36-bit register file. It sits on the same request and acknowledge bus that carries main-memory traffic. Several processor ports reach it. A static select input chooses the single port it answers, and it ignores the request, data and restart pins of every other port. A master on the chosen port starts a cycle with a cycle request. The same cycle carries the read and write request flags and a 4-bit word address. A cycle may be a read, a write, or a read-modify-write.

A read returns the addressed word on the shared read-data lines together with a one-cycle read-restart strobe. A read-only cycle finishes at once. A write clears the addressed word when the cycle is accepted and opens a write window. While the window is open, every nonzero data word the master drives is ORed into the stored word, and a write-restart pulse closes the window. A read-modify-write returns the old word first and then behaves as a write. Back-pressure on this bus comes only from the block's busy state. A master holds its cycle request until it sees address acknowledge, then drops it. While the block is busy a request gets no acknowledge and simply waits. Acknowledge and read-restart are single-cycle pulses and have no ready signal.

Top module: `fastreg_mem`

## Requirements
- R1: Only the port whose index equals `sel_port` is served. Requests, data and write-restart pulses on any other port produce no acknowledge and no read-restart, and they change neither the stored words nor the open write window. Acknowledge and read-restart bits are only ever raised at bit position `sel_port`.
- R2: A cycle request seen while the block is idle is accepted at that clock edge. `addr_ack` then pulses high for exactly one cycle on the selected port, in the cycle after the request was sampled.
- R3: While a write window is open, further cycle requests get no acknowledge and no read-restart.
- R4: A request with the read flag returns the addressed word on `rdata` with a one-cycle `rd_rs` pulse in the same cycle as `addr_ack`. A read without the write flag leaves the block idle, so a new request in the very next cycle is accepted.
- R5: A request with the write flag captures the address, clears the addressed word at acceptance and opens the write window.
- R6: While the window is open and the read flag is low, each nonzero `wdata` word is ORed into the captured word, so several data beats accumulate.
- R7: While the read flag stays high, data is not merged, even when the window is open.
- R8: A write-restart pulse on the selected port closes the window, and data driven after it is not merged. The pulse wins over a request accepted in the same cycle.
- R9: A read-modify-write (read and write flags both set) returns the old word and then stores the data written in its window.
- R10: During reset the flags are cleared, `addr_ack` and `rd_rs` are low and every word reads back as zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sel_port | input | SELW | Index of the served port (static) |
| cyc_rq | input | NPORTS | Cycle request, one per port |
| rd_rq | input | NPORTS | Read flag, one per port |
| wr_rq | input | NPORTS | Write flag, one per port |
| wr_rs | input | NPORTS | Write-restart pulse, one per port |
| addr | input | NPORTS x 4 | Word address, one per port |
| wdata | input | NPORTS x 36 | Write data, one per port |
| addr_ack | output | NPORTS | Address acknowledge pulse, one per port |
| rd_rs | output | NPORTS | Read-restart pulse, one per port |
| rdata | output | 36 | Read data, valid with `rd_rs` |

## Verification
The hardest state to reach is a write window that stays open while something else happens. Examples are a second request arriving, the read flag staying high during a data beat, or a foreign port pulsing write-restart. No single bus transaction creates these states. Directed sequences therefore accept a write, then inject the disturbing event at a chosen cycle before closing the window. The result is read back through a normal read cycle, so the effect shows at the ports.

// File: rtl/fastreg_pkg.sv
package fastreg_pkg;
  localparam int WORD_W = 36;
  localparam int ADDR_W = 4;
  localparam int DEPTH  = 1 << ADDR_W;

  typedef logic [WORD_W-1:0] word_t;
  typedef logic [ADDR_W-1:0] waddr_t;

  // One port's request as seen after the port selector.
  typedef struct packed {
    logic   cyc;
    logic   rd;
    logic   wr;
    logic   wrs;
    waddr_t addr;
    word_t  data;
  } req_t;
endpackage

// File: rtl/fastreg_port_sel.sv
module fastreg_port_sel
  import fastreg_pkg::*;
#(
  parameter int NPORTS = 4,
  localparam int SELW = (NPORTS > 1) ? $clog2(NPORTS) : 1
) (
  input  logic [SELW-1:0]               sel,
  input  logic [NPORTS-1:0]             cyc_i,
  input  logic [NPORTS-1:0]             rd_i,
  input  logic [NPORTS-1:0]             wr_i,
  input  logic [NPORTS-1:0]             wrs_i,
  input  logic [NPORTS-1:0][ADDR_W-1:0] addr_i,
  input  logic [NPORTS-1:0][WORD_W-1:0] data_i,
  output req_t                          req_o,
  output logic [NPORTS-1:0]             mask_o
);
  req_t per_port [NPORTS];

  for (genvar g = 0; g < NPORTS; g++) begin : g_port
    assign per_port[g] = '{cyc: cyc_i[g], rd: rd_i[g], wr: wr_i[g],
                           wrs: wrs_i[g], addr: addr_i[g], data: data_i[g]};
    assign mask_o[g]   = (sel == SELW'(g));
  end

  always_comb begin
    req_o = '0;
    for (int i = 0; i < NPORTS; i++)
      if (mask_o[i]) req_o = per_port[i];
  end
endmodule

// File: rtl/fastreg_seq.sv
module fastreg_seq
  import fastreg_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  req_t   req,
  output logic   rd_en,
  output logic   clr_en,
  output waddr_t acc_addr,
  output logic   or_en,
  output waddr_t or_addr,
  output logic   ack_q,
  output logic   rd_rs_q
);
  logic   active_q, pend_q;
  waddr_t addr_q;
  logic   accept;

  assign accept   = !active_q && req.cyc;
  assign rd_en    = accept && req.rd;
  assign clr_en   = accept && req.wr;
  assign acc_addr = req.addr;
  assign or_en    = active_q && pend_q && !req.rd && (req.data != '0);
  assign or_addr  = addr_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      active_q <= 1'b0;
      pend_q   <= 1'b0;
      addr_q   <= '0;
      ack_q    <= 1'b0;
      rd_rs_q  <= 1'b0;
    end else begin
      ack_q   <= accept;
      rd_rs_q <= rd_en;
      if (accept) addr_q <= req.addr;
      if (req.wrs) begin
        active_q <= 1'b0;
        pend_q   <= 1'b0;
      end else if (accept) begin
        active_q <= !(req.rd && !req.wr);
        pend_q   <= req.wr;
      end
    end
  end

  assert_busy_no_ack_R3: assert property (@(posedge clk) disable iff (!rst_n)
    active_q |=> !ack_q);
  assert_rdrs_with_ack_R4: assert property (@(posedge clk) disable iff (!rst_n)
    rd_rs_q |-> ack_q);
  assert_pend_needs_active_R5: assert property (@(posedge clk) disable iff (!rst_n)
    pend_q |-> active_q);
  assert_restart_closes_R8: assert property (@(posedge clk) disable iff (!rst_n)
    req.wrs |=> (!active_q && !pend_q));
endmodule

// File: rtl/fastreg_bank.sv
module fastreg_bank
  import fastreg_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   rd_en,
  input  logic   clr_en,
  input  waddr_t acc_addr,
  input  logic   or_en,
  input  waddr_t or_addr,
  input  word_t  or_data,
  output word_t  rdata
);
  word_t words [DEPTH];

  for (genvar g = 0; g < DEPTH; g++) begin : g_word
    always_ff @(posedge clk) begin
      if (!rst_n)
        words[g] <= '0;
      else if (clr_en && acc_addr == ADDR_W'(g))
        words[g] <= '0;
      else if (or_en && or_addr == ADDR_W'(g))
        words[g] <= words[g] | or_data;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)     rdata <= '0;
    else if (rd_en) rdata <= words[acc_addr];
  end

  assert_clear_on_accept_R5: assert property (@(posedge clk) disable iff (!rst_n)
    clr_en |=> (words[$past(acc_addr)] == '0));
  assert_or_accum_R6: assert property (@(posedge clk) disable iff (!rst_n)
    or_en |=> ((words[$past(or_addr)] & $past(or_data)) == $past(or_data)));
endmodule

// File: rtl/fastreg_mem.sv
module fastreg_mem
  import fastreg_pkg::*;
#(
  parameter int NPORTS = 4,
  localparam int SELW = (NPORTS > 1) ? $clog2(NPORTS) : 1
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic [SELW-1:0]               sel_port,
  input  logic [NPORTS-1:0]             cyc_rq,
  input  logic [NPORTS-1:0]             rd_rq,
  input  logic [NPORTS-1:0]             wr_rq,
  input  logic [NPORTS-1:0]             wr_rs,
  input  logic [NPORTS-1:0][ADDR_W-1:0] addr,
  input  logic [NPORTS-1:0][WORD_W-1:0] wdata,
  output logic [NPORTS-1:0]             addr_ack,
  output logic [NPORTS-1:0]             rd_rs,
  output logic [WORD_W-1:0]             rdata
);
  req_t              req;
  logic [NPORTS-1:0] mask;
  logic              rd_en, clr_en, or_en, ack_q, rd_rs_q;
  waddr_t            acc_addr, or_addr;

  fastreg_port_sel #(.NPORTS(NPORTS)) u_sel (
    .sel(sel_port), .cyc_i(cyc_rq), .rd_i(rd_rq), .wr_i(wr_rq),
    .wrs_i(wr_rs), .addr_i(addr), .data_i(wdata),
    .req_o(req), .mask_o(mask));

  fastreg_seq u_seq (
    .clk(clk), .rst_n(rst_n), .req(req),
    .rd_en(rd_en), .clr_en(clr_en), .acc_addr(acc_addr),
    .or_en(or_en), .or_addr(or_addr),
    .ack_q(ack_q), .rd_rs_q(rd_rs_q));

  fastreg_bank u_bank (
    .clk(clk), .rst_n(rst_n), .rd_en(rd_en), .clr_en(clr_en),
    .acc_addr(acc_addr), .or_en(or_en), .or_addr(or_addr),
    .or_data(req.data), .rdata(rdata));

  assign addr_ack = ack_q   ? mask : '0;
  assign rd_rs    = rd_rs_q ? mask : '0;

  assert_ack_sel_port_R1: assert property (@(posedge clk) disable iff (!rst_n)
    ((addr_ack | rd_rs) & ~(NPORTS'(1) << sel_port)) == '0);
  assert_ack_single_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(addr_ack));
endmodule

// File: tb/fastreg_mem_test.sv
module fastreg_mem_test;
  localparam int CLK_PERIOD = 10;
  localparam int P = 4;
  localparam int WD = 20000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [1:0] sel_port = 2'd2;
  logic [P-1:0] cyc_rq = '0, rd_rq = '0, wr_rq = '0, wr_rs = '0;
  logic [P-1:0][3:0]  addr  = '0;
  logic [P-1:0][35:0] wdata = '0;
  logic [P-1:0] addr_ack, rd_rs;
  logic [35:0]  rdata;
  int n_chk = 0, n_bad = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  fastreg_mem #(.NPORTS(P)) uut (
    .clk(clk), .rst_n(rst_n), .sel_port(sel_port), .cyc_rq(cyc_rq),
    .rd_rq(rd_rq), .wr_rq(wr_rq), .wr_rs(wr_rs), .addr(addr),
    .wdata(wdata), .addr_ack(addr_ack), .rd_rs(rd_rs), .rdata(rdata));

  // op: 0 write, 1 read, 2 read-modify-write
  typedef struct packed {
    logic [1:0]  op;
    logic [1:0]  port;
    logic [3:0]  a;
    logic [35:0] d1;
    logic [35:0] d2;
    logic [35:0] ex;
  } vec_t;

  localparam int NV = 13;
  localparam vec_t VECS [NV] = '{
    '{2'd0, 2'd2, 4'd3,  36'h0_0000_0F0F, 36'h0_3000_0000, 36'h0},
    '{2'd1, 2'd2, 4'd3,  36'h0,           36'h0,           36'h0_3000_0F0F},
    '{2'd0, 2'd1, 4'd3,  36'h0_0000_0FFF, 36'h0,           36'h0},
    '{2'd1, 2'd2, 4'd3,  36'h0,           36'h0,           36'h0_3000_0F0F},
    '{2'd0, 2'd2, 4'd15, 36'hF_FFFF_FFFF, 36'h0,           36'h0},
    '{2'd1, 2'd2, 4'd15, 36'h0,           36'h0,           36'hF_FFFF_FFFF},
    '{2'd2, 2'd2, 4'd15, 36'h0_0000_1234, 36'h0,           36'hF_FFFF_FFFF},
    '{2'd1, 2'd2, 4'd15, 36'h0,           36'h0,           36'h0_0000_1234},
    '{2'd1, 2'd0, 4'd15, 36'h0,           36'h0,           36'h0},
    '{2'd0, 2'd2, 4'd0,  36'h8_0000_0001, 36'h8_0000_0001, 36'h0},
    '{2'd1, 2'd2, 4'd0,  36'h0,           36'h0,           36'h8_0000_0001},
    '{2'd0, 2'd2, 4'd3,  36'h0,           36'h0_0000_0005, 36'h0},
    '{2'd1, 2'd2, 4'd3,  36'h0,           36'h0,           36'h0_0000_0005}
  };

  task automatic check(input bit ok, input string req, input logic [35:0] act,
                       input logic [35:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // One full transaction; checks acknowledge, read-restart and read data.
  task automatic txn(input int p, input int op, input logic [3:0] a,
                     input logic [35:0] d1, input logic [35:0] d2,
                     input logic [35:0] ex);
    logic [P-1:0] m;
    bit acc;
    acc = (p == int'(sel_port));
    m   = acc ? (P'(1) << p) : '0;
    @(negedge clk);
    cyc_rq[p] = 1'b1; rd_rq[p] = (op != 0); wr_rq[p] = (op != 1);
    addr[p] = a; wdata[p] = '0;
    @(posedge clk); #1;
    check(addr_ack == m, acc ? "R2 ack" : "R1 foreign ack", 36'(addr_ack), 36'(m));
    if (op != 0) begin
      check(rd_rs == m, acc ? "R4 rd_rs" : "R1 foreign rd_rs", 36'(rd_rs), 36'(m));
      if (acc) check(rdata == ex, op == 2 ? "R9 old word" : "R4 rdata", rdata, ex);
    end
    @(negedge clk);
    cyc_rq[p] = 1'b0; rd_rq[p] = 1'b0;
    if (op != 1) begin
      wdata[p] = d1;
      @(negedge clk); wdata[p] = d2;
      @(negedge clk); wdata[p] = '0; wr_rs[p] = 1'b1;
      @(negedge clk); wr_rs[p] = 1'b0; wr_rq[p] = 1'b0;
    end
  endtask

  task automatic summary;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    repeat (WD) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=running expected=done");
    summary();
  end

  initial begin
    repeat (3) @(posedge clk); #1;
    check(addr_ack == '0 && rd_rs == '0, "R10 outputs in reset", 36'({addr_ack, rd_rs}), 36'h0);
    @(negedge clk); rst_n = 1'b1;
    txn(2, 1, 4'd7, 0, 0, 36'h0);                    // R10 words zero

    for (int i = 0; i < NV; i++)
      txn(int'(VECS[i].port), int'(VECS[i].op), VECS[i].a,
          VECS[i].d1, VECS[i].d2, VECS[i].ex);

    // R3: request while the write window is open
    @(negedge clk); cyc_rq[2] = 1; wr_rq[2] = 1; addr[2] = 4'd4;
    @(negedge clk); rd_rq[2] = 1; addr[2] = 4'd9;
    @(posedge clk); #1;
    check(addr_ack == '0 && rd_rs == '0, "R3 busy no ack", 36'({addr_ack, rd_rs}), 36'h0);
    @(negedge clk); cyc_rq[2] = 0; rd_rq[2] = 0; wdata[2] = 36'hA;
    @(negedge clk); wdata[2] = 0; wr_rs[2] = 1;
    @(negedge clk); wr_rs[2] = 0; wr_rq[2] = 0;
    txn(2, 1, 4'd4, 0, 0, 36'hA);                    // R3 word 4 intact

    // R7: read flag high blocks the merge
    @(negedge clk); cyc_rq[2] = 1; wr_rq[2] = 1; addr[2] = 4'd6;
    @(negedge clk); cyc_rq[2] = 0; rd_rq[2] = 1; wdata[2] = 36'hFF;
    @(negedge clk); rd_rq[2] = 0; wdata[2] = 36'h100;
    @(negedge clk); wdata[2] = 0; wr_rs[2] = 1;
    @(negedge clk); wr_rs[2] = 0; wr_rq[2] = 0;
    txn(2, 1, 4'd6, 0, 0, 36'h100);                  // R7

    // R1: foreign write-restart keeps the window open
    @(negedge clk); cyc_rq[2] = 1; wr_rq[2] = 1; addr[2] = 4'd8;
    @(negedge clk); cyc_rq[2] = 0; wr_rs[1] = 1;
    @(negedge clk); wr_rs[1] = 0; wdata[2] = 36'h7;
    @(negedge clk); wdata[2] = 0; wr_rs[2] = 1;
    // R8: data after the restart is not merged
    @(negedge clk); wr_rs[2] = 0; wdata[2] = 36'h70;
    @(negedge clk); wdata[2] = 0; wr_rq[2] = 0;
    txn(2, 1, 4'd8, 0, 0, 36'h7);                    // R1, R8

    // R8: restart wins over a request in the same cycle
    @(negedge clk); cyc_rq[2] = 1; wr_rq[2] = 1; addr[2] = 4'd9; wr_rs[2] = 1;
    @(negedge clk); cyc_rq[2] = 0; wr_rs[2] = 0; wdata[2] = 36'h3;
    @(negedge clk); wdata[2] = 0; wr_rq[2] = 0;
    txn(2, 1, 4'd9, 0, 0, 36'h0);                    // R8 window never opened

    // R4: back-to-back reads both accepted
    @(negedge clk); cyc_rq[2] = 1; rd_rq[2] = 1; addr[2] = 4'd4;
    @(posedge clk); #1;
    check(addr_ack == 4'b0100, "R4 first read ack", 36'(addr_ack), 36'h4);
    @(negedge clk); addr[2] = 4'd6;
    @(posedge clk); #1;
    check(addr_ack == 4'b0100 && rdata == 36'h100, "R4 second read", rdata, 36'h100);
    @(negedge clk); cyc_rq[2] = 0; rd_rq[2] = 0;

    // R1: moving the selection serves the new port
    sel_port = 2'd0;
    txn(0, 1, 4'd15, 0, 0, 36'h1234);
    txn(2, 1, 4'd15, 0, 0, 36'h0);                   // R1 old port now foreign

    repeat (2) @(negedge clk);
    summary();
  end
endmodule